// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the peripheral clock. A power-of-two prescaler turns the peripheral clock into an internal tick. Two phase counters, one for the high level and one for the low level of the serial clock, then count ticks, so the output frequency and its duty cycle are set independently by three 4-bit fields: a scale exponent, a high-phase count and a low-phase count.

A shift engine beside it uses the serial clock and the one-cycle strobes marking every rising and falling transition. The fields are captured only while the generator is disabled, so a running transfer never sees a phase cut short. Settings the generator cannot honour raise a configuration-error flag and keep the clock at its idle low level. With all three fields at zero the generator toggles on every peripheral clock, the fastest rate it offers.

Top module: `spi_sclk_gen`

## Requirements
- R1: The internal tick occurs once every 2^scale peripheral clocks, so every high and low phase lasts a whole multiple of 2^scale cycles and the serial clock changes level only on a tick.
- R2: With scale from 0 to 8 and hi from 1 to 15, each complete high phase of sclk_o lasts hi * 2^scale peripheral clock cycles.
- R3: With scale from 0 to 8 and lo from 1 to 15, each complete low phase lasts lo * 2^scale cycles, and the first low phase after enable is complete as well: sclk_o first reads high lo * 2^scale cycles after the first enabled clock edge.
- R4: With scale equal to 0, a hi or lo value of 0 makes that phase last one tick; with scale, hi and lo all 0, sclk_o toggles on every peripheral clock edge while enabled, reading high from the first enabled edge on.
- R5: A configuration is in error when scale is 9 or more, or when scale is not 0 and hi or lo is 0; cfg_err_o is then 1, and while enabled sclk_o stays 0 and neither strobe fires.
- R6: When en_i is 0 at a clock edge, sclk_o is 0 after that edge, and the prescaler and phase counters restart from zero, so the next enable begins with a full low phase.
- R7: scale_i, hi_i and lo_i are captured at every clock edge where en_i is 0 and held while en_i is 1; changes made while enabled have no effect on sclk_o or cfg_err_o until the next disable.
- R8: rise_o is 1 for exactly the one cycle in which sclk_o has just gone from 0 to 1, and fall_o for the one cycle in which it has just gone from 1 to 0 (including the drop caused by a disable); the two are never 1 together.
- R9: During and right after reset sclk_o, rise_o, fall_o and cfg_err_o are 0, and the captured configuration is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run the generator; configuration is captured while low |
| scale_i | input | 4 | Prescaler exponent, tick = clock / 2^scale |
| hi_i | input | 4 | Ticks per high phase |
| lo_i | input | 4 | Ticks per low phase |
| sclk_o | output | 1 | Serial clock, idle low |
| cfg_err_o | output | 1 | Captured configuration is unusable |
| rise_o | output | 1 | sclk_o has just risen |
| fall_o | output | 1 | sclk_o has just fallen |

## Verification
The assertions assume that the configuration inputs may move at any time but that the captured copy changes only in cycles following a low en_i, and that en_i is a clean synchronous level. The tick-spacing property relies on the captured scale staying fixed while running, so it allows a tick right after a disable-reenable only when the new scale is 0. The directed stimulus changes scale_i, hi_i and lo_i only at falling clock edges, holds them for several cycles with en_i low before enabling, and deliberately moves them once during a run to show they are ignored there.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  localparam int unsigned CFG_W     = 4;
  localparam int unsigned SCALE_MAX = 8;

  typedef struct packed {
    logic [CFG_W-1:0] scale;
    logic [CFG_W-1:0] hi;
    logic [CFG_W-1:0] lo;
  } sclk_cfg_t;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_DIV    = 2'd1,
    MODE_ERR    = 2'd2
  } sclk_mode_e;

endpackage

// File: rtl/spi_sclk_cfg.sv
module spi_sclk_cfg
  import spi_sclk_pkg::*;
#(
  parameter int unsigned SCALE_LIM = SCALE_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  sclk_cfg_t  cfg_i,
  output sclk_cfg_t  cfg_o,
  output sclk_mode_e mode_o
);

  sclk_cfg_t cfg_q;

  // capture only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (!en_i) cfg_q <= cfg_i;
  end

  logic scale_bad, phase_zero;

  always_comb begin
    scale_bad  = (int'(cfg_q.scale) > int'(SCALE_LIM));
    phase_zero = (cfg_q.hi == '0) || (cfg_q.lo == '0);
    if (scale_bad || ((cfg_q.scale != '0) && phase_zero))
      mode_o = MODE_ERR;
    else if ((cfg_q.scale == '0) && (cfg_q.hi == '0) && (cfg_q.lo == '0))
      mode_o = MODE_BYPASS;
    else
      mode_o = MODE_DIV;
  end

  assign cfg_o = cfg_q;

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> $stable(cfg_q)); // R7

endmodule

// File: rtl/spi_sclk_prescale.sv
module spi_sclk_prescale
  import spi_sclk_pkg::*;
#(
  parameter int unsigned SCALE_LIM = SCALE_MAX,
  parameter int unsigned EXP_W     = CFG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [EXP_W-1:0] scale_i,
  output logic             tick_o
);

  localparam int unsigned CNT_W = (SCALE_LIM > 0) ? SCALE_LIM : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;

  assign span   = (CNT_W+1)'(1) << scale_i;
  assign limit  = CNT_W'(span - 1'b1);
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (scale_i != '0)) |=> (!tick_o || (scale_i == '0))); // R1

endmodule

// File: rtl/spi_sclk_phase.sv
module spi_sclk_phase
  import spi_sclk_pkg::*;
#(
  parameter int unsigned CNT_W = CFG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [CNT_W-1:0] hi_eff, lo_eff, lim, ph_cnt_q;
  logic             sclk_q, sclk_prev_q;

  // zero count means a single tick
  assign hi_eff = (hi_i == '0) ? CNT_W'(1) : hi_i;
  assign lo_eff = (lo_i == '0) ? CNT_W'(1) : lo_i;
  assign lim    = sclk_q ? hi_eff : lo_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      ph_cnt_q <= '0;
    end else if (!run_i) begin
      sclk_q   <= 1'b0;
      ph_cnt_q <= '0;
    end else if (tick_i) begin
      if (ph_cnt_q == lim - 1'b1) begin
        sclk_q   <= ~sclk_q;
        ph_cnt_q <= '0;
      end else begin
        ph_cnt_q <= ph_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_q;
  end

  assign sclk_o = sclk_q;
  assign rise_o = sclk_q & ~sclk_prev_q;
  assign fall_o = ~sclk_q & sclk_prev_q;

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sclk_o); // R6
  AST_MOVE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> (sclk_o == $past(sclk_o))); // R1
  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o})); // R8
  AST_RISE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> rise_o); // R8

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [3:0] scale_i,
  input  logic [3:0] hi_i,
  input  logic [3:0] lo_i,
  output logic       sclk_o,
  output logic       cfg_err_o,
  output logic       rise_o,
  output logic       fall_o
);

  sclk_cfg_t  cfg_in, cfg_q;
  sclk_mode_e mode;
  logic       run, tick;

  assign cfg_in = '{scale: scale_i, hi: hi_i, lo: lo_i};

  spi_sclk_cfg #(.SCALE_LIM(SCALE_MAX)) i_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .cfg_i (cfg_in),
    .cfg_o (cfg_q),
    .mode_o(mode)
  );

  assign run       = en_i && (mode != MODE_ERR);
  assign cfg_err_o = (mode == MODE_ERR);

  spi_sclk_prescale #(.SCALE_LIM(SCALE_MAX), .EXP_W(CFG_W)) i_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .scale_i(cfg_q.scale),
    .tick_o (tick)
  );

  spi_sclk_phase #(.CNT_W(CFG_W)) i_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(tick),
    .hi_i  (cfg_q.hi),
    .lo_i  (cfg_q.lo),
    .sclk_o(sclk_o),
    .rise_o(rise_o),
    .fall_o(fall_o)
  );

  AST_ERR_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !sclk_o); // R5
  AST_BYPASS_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && (mode == MODE_BYPASS)) |=> (sclk_o != $past(sclk_o))); // R4

endmodule

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] scale = '0, hi = '0, lo = '0;
  logic       sclk, cfg_err, rise, fall;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  spi_sclk_gen i_spi_sclk_gen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .scale_i  (scale),
    .hi_i     (hi),
    .lo_i     (lo),
    .sclk_o   (sclk),
    .cfg_err_o(cfg_err),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // enable with a config, sample N cycles at falling edges
  task automatic measure(input logic [3:0] s, h, l, input int n,
                         input int chg_at, input logic [3:0] s2, h2, l2,
                         output int first_rise, output int hmin, output int hmax,
                         output int lmin, output int lmax, output int strobe_bad,
                         output int rises, output int err_seen);
    logic prev, cur;
    int   run_len;
    bit   seen_edge;
    @(negedge clk);
    en = 1'b0; scale = s; hi = h; lo = l;
    repeat (3) @(negedge clk);
    en = 1'b1;
    first_rise = -1; hmin = 1 << 30; hmax = -1; lmin = 1 << 30; lmax = -1;
    strobe_bad = 0; rises = 0; err_seen = 0;
    prev = 1'b0; run_len = 0; seen_edge = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      cur = sclk;
      if (i == 1) err_seen = int'(cfg_err);
      if (rise !== (cur & ~prev)) strobe_bad++;
      if (fall !== (~cur & prev)) strobe_bad++;
      if (cur != prev) begin
        if (cur) rises++;
        if (cur && first_rise < 0) first_rise = i;
        if (seen_edge) begin
          if (prev) begin
            if (run_len < hmin) hmin = run_len;
            if (run_len > hmax) hmax = run_len;
          end else begin
            if (run_len < lmin) lmin = run_len;
            if (run_len > lmax) lmax = run_len;
          end
        end
        seen_edge = 1'b1;
        run_len = 1;
      end else begin
        run_len++;
      end
      prev = cur;
      if (i == chg_at) begin
        scale = s2; hi = h2; lo = l2;
      end
    end
    en = 1'b0;
  endtask

  task automatic t_divided(input string req, input logic [3:0] s, h, l, input int n);
    int fr, hmn, hmx, lmn, lmx, sb, rs, er, he, le;
    he = ((h == 0) ? 1 : int'(h)) << s;
    le = ((l == 0) ? 1 : int'(l)) << s;
    measure(s, h, l, n, 0, 0, 0, 0, fr, hmn, hmx, lmn, lmx, sb, rs, er);
    chk(req, "R3 first rise index", fr, le);
    chk(req, "R2 high phase min", hmn, he);
    chk(req, "R2 high phase max", hmx, he);
    chk(req, "R3 low phase min", lmn, le);
    chk(req, "R3 low phase max", lmx, le);
    chk(req, "R8 strobe mismatches", sb, 0);
    chk(req, "R5 no error flag", er, 0);
  endtask

  task automatic t_reset;
    chk("R9", "sclk in reset", int'(sclk), 0);
    chk("R9", "strobes in reset", int'(rise | fall), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "sclk after reset", int'(sclk), 0);
    chk("R9", "cfg_err after reset", int'(cfg_err), 0);
  endtask

  task automatic t_bypass;
    int fr, hmn, hmx, lmn, lmx, sb, rs, er;
    measure(0, 0, 0, 24, 0, 0, 0, 0, fr, hmn, hmx, lmn, lmx, sb, rs, er);
    chk("R4", "bypass first high sample", fr, 1);
    chk("R4", "bypass high max", hmx, 1);
    chk("R4", "bypass low max", lmx, 1);
    chk("R4", "bypass rises", rs, 12);
    chk("R8", "bypass strobes", sb, 0);
  endtask

  task automatic t_error(input logic [3:0] s, h, l);
    int fr, hmn, hmx, lmn, lmx, sb, rs, er;
    measure(s, h, l, 60, 0, 0, 0, 0, fr, hmn, hmx, lmn, lmx, sb, rs, er);
    chk("R5", $sformatf("err flag s%0d h%0d l%0d", s, h, l), er, 1);
    chk("R5", "sclk stayed low", rs, 0);
    chk("R5", "no strobes", sb, 0);
  endtask

  task automatic t_cfg_frozen;
    int fr, hmn, hmx, lmn, lmx, sb, rs, er;
    measure(1, 2, 2, 200, 30, 9, 1, 1, fr, hmn, hmx, lmn, lmx, sb, rs, er);
    chk("R7", "high phase unchanged", hmx, 4);
    chk("R7", "high phase min unchanged", hmn, 4);
    chk("R7", "low phase unchanged", lmx, 4);
    chk("R7", "no strobe glitches", sb, 0);
    chk("R7", "err flag unchanged while running", int'(cfg_err), 0);
    repeat (2) @(negedge clk);
    chk("R7", "new config captured after disable", int'(cfg_err), 1);
  endtask

  task automatic t_disable;
    int guard = 0;
    @(negedge clk);
    en = 1'b0; scale = 0; hi = 3; lo = 3;
    repeat (3) @(negedge clk);
    en = 1'b1;
    while (sclk !== 1'b1 && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk("R6", "reached high before disable", int'(sclk), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R6", "sclk low after disable", int'(sclk), 0);
    chk("R8", "fall strobe on disable", int'(fall), 1);
    @(negedge clk);
    chk("R8", "fall strobe one cycle", int'(fall), 0);
    // midway through a low phase then quick restart: full low phase expected
    en = 1'b1;
    repeat (2) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    t_divided("R6", 0, 3, 3, 40);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_divided("R2", 0, 3, 2, 60);
    t_divided("R1", 2, 1, 4, 200);
    t_divided("R1", 8, 1, 1, 1400);
    t_divided("R3", 3, 15, 15, 1200);
    t_divided("R4", 0, 0, 5, 60);
    t_divided("R4", 0, 4, 0, 60);
    t_error(9, 1, 1);
    t_error(3, 0, 2);
    t_error(5, 4, 0);
    t_error(15, 15, 15);
    t_cfg_frozen();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule